// File: doc/BRIEF.md
# Class-Aware Issue Interlock Scoreboard

This block sits at the decode stage of an in-order pipeline. It decides whether the instruction waiting there may issue this cycle. It serves a machine whose integer, load and floating-point ALU operations deliver their results after different delays. For every architectural register it keeps a small countdown of the cycles left before a pending result is usable, and it remembers which kind of operation produced that result. A waiting instruction names up to two source registers. Each source is tagged with the way the instruction will use it: as an integer operand, as a floating-point ALU operand, or as the data of a store. The instruction is held until every enabled source has waited long enough for its own producer/consumer pairing.

The decode stage offers an instruction on a valid/ready handshake. The instruction issues on a cycle where `in_valid` and `in_ready` are both high. The scoreboard then arms the countdown for the destination, unless the instruction writes no register. `in_ready` is combinational from the current state and the offered source fields, so the offer is held for the whole stall. The block adds no rule against withdrawal: an offer dropped while stalled leaves no trace. `issue_stall` is the plain stall flag for the stages upstream, and is high only while an offered instruction is being held. `advance` lets the countdowns step. When it is low, everything freezes in place.

Top module: `isb_scoreboard`

## Requirements
- R1: After reset every register is ready: no source read, of any use class, causes a stall until an instruction issues.
- R2: A floating-point ALU result (producer code 3) read as a floating-point ALU operand (use code 1) by an instruction offered the cycle after the producer issued stalls it for 3 cycles, one fewer for each advancing cycle already elapsed, never below zero.
- R3: A floating-point ALU result read as store data (use code 2) needs 2 stall cycles under the same counting.
- R4: A load result (producer code 2) read as a floating-point ALU operand needs 1 stall cycle.
- R5: A load result read as store data needs no stall. A load result read as an integer operand (use code 0) needs 1 stall cycle.
- R6: An integer result (producer code 1) never causes a stall, whatever the use class.
- R7: A floating-point ALU result read as an integer operand needs 3 stall cycles.
- R8: While `advance` is low, no countdown moves. A stalled instruction stays stalled for as long as `advance` stays low, and the stalls it still needs once `advance` returns are unchanged.
- R9: Issuing a new producer to a register with a pending result replaces that countdown with the new producer's delay.
- R10: `in_ready` is the inverse of the hazard and `issue_stall` is `in_valid` AND the hazard. A held or withdrawn offer arms no countdown for its destination.
- R11: Disabled sources, reads of other registers, and instructions with producer code 0 (no destination) cause no stall and arm nothing.
- R12: With two enabled sources, the instruction waits for the larger of the two remaining requirements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| advance | input | 1 | Pipeline tick; countdowns step only when high |
| in_valid | input | 1 | Decode offers an instruction |
| in_ready | output | 1 | Offered instruction may issue this cycle |
| in_prod | input | 2 | Producer class: 0 none, 1 integer, 2 load, 3 FP ALU |
| in_dst | input | RW | Destination register |
| src0_en | input | 1 | Source 0 is read |
| src0_reg | input | RW | Source 0 register |
| src0_use | input | 2 | Source 0 use: 0 integer, 1 FP ALU, 2 store data |
| src1_en | input | 1 | Source 1 is read |
| src1_reg | input | RW | Source 1 register |
| src1_use | input | 2 | Source 1 use class |
| issue_stall | output | 1 | Offered instruction is held this cycle |

## Verification
The stall outputs are combinational from the registered countdowns, so they answer in the same cycle that a source is offered. A countdown armed at an issuing edge shows its full value in the very next cycle, and each advancing cycle after that removes one. The bench drives inputs just after a rising edge and samples at the falling edge. For every producer, use class and idle gap from 0 to 4, it counts falling edges with `issue_stall` high and compares the count with the required delay minus the gap, floored at zero.

// File: rtl/isb_pkg.sv
package isb_pkg;

  typedef enum logic [1:0] {
    PROD_NONE = 2'd0,
    PROD_INT  = 2'd1,
    PROD_LOAD = 2'd2,
    PROD_FPU  = 2'd3
  } prod_e;

  typedef enum logic [1:0] {
    USE_INT   = 2'd0,
    USE_FPU   = 2'd1,
    USE_STORE = 2'd2,
    USE_RSVD  = 2'd3
  } use_e;

  localparam int MAX_WAIT = 3;
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);

  // Cycles a consumer of class u must sit out after producer class p issued.
  function automatic logic [CNT_W-1:0] wait_need(prod_e p, use_e u);
    logic [CNT_W-1:0] n;
    n = '0;
    unique case (p)
      PROD_FPU: begin
        if (u == USE_STORE) n = CNT_W'(2);
        else                n = CNT_W'(3);
      end
      PROD_LOAD: begin
        if (u == USE_STORE) n = CNT_W'(0);
        else                n = CNT_W'(1);
      end
      default: n = '0;
    endcase
    return n;
  endfunction

  // Countdown armed at issue: worst requirement over all consumer classes.
  function automatic logic [CNT_W-1:0] hold_len(prod_e p);
    logic [CNT_W-1:0] m;
    m = '0;
    for (int u = 0; u < 3; u++) begin
      if (wait_need(p, use_e'(u)) > m) m = wait_need(p, use_e'(u));
    end
    return m;
  endfunction

endpackage

// File: rtl/isb_slot.sv
module isb_slot
  import isb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  prod_e            load_cls,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output prod_e            cls
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      cls <= PROD_NONE;
    end else if (load) begin
      cnt <= load_val;
      cls <= load_cls;
    end else if (tick && (cnt != '0)) begin
      cnt <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/isb_src_gate.sv
module isb_src_gate
  import isb_pkg::*;
#(
  parameter int RW = 5,
  localparam int NREGS = 1 << RW
) (
  input  logic                        en,
  input  logic [RW-1:0]               idx,
  input  logic [1:0]                  use_code,
  input  logic [NREGS-1:0][CNT_W-1:0] cnt_vec,
  input  logic [NREGS-1:0][1:0]       cls_vec,
  output logic                        blocked
);

  logic [CNT_W-1:0] left;
  prod_e            who;
  logic [CNT_W:0]   used_up;
  logic [CNT_W:0]   limit;

  always_comb begin
    left    = cnt_vec[idx];
    who     = prod_e'(cls_vec[idx]);
    // elapsed-so-far view: need + remaining must fit inside the armed hold
    used_up = {1'b0, left} + {1'b0, wait_need(who, use_e'(use_code))};
    limit   = {1'b0, hold_len(who)};
    blocked = en && (used_up > limit);
  end

endmodule

// File: rtl/isb_scoreboard.sv
module isb_scoreboard
  import isb_pkg::*;
#(
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          advance,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    in_prod,
  input  logic [RW-1:0] in_dst,
  input  logic          src0_en,
  input  logic [RW-1:0] src0_reg,
  input  logic [1:0]    src0_use,
  input  logic          src1_en,
  input  logic [RW-1:0] src1_reg,
  input  logic [1:0]    src1_use,
  output logic          issue_stall
);

  localparam int NREGS = 1 << RW;

  logic [NREGS-1:0][CNT_W-1:0] cnt_vec;
  logic [NREGS-1:0][1:0]       cls_vec;
  logic                        blk0, blk1, hazard, accept, writes;
  prod_e                       prod;
  logic [CNT_W-1:0]            arm_val;

  assign prod    = prod_e'(in_prod);
  assign arm_val = hold_len(prod);
  assign hazard  = blk0 | blk1;
  assign accept  = in_valid & ~hazard;
  assign writes  = accept & (prod != PROD_NONE);

  assign in_ready    = ~hazard;
  assign issue_stall = in_valid & hazard;

  for (genvar i = 0; i < NREGS; i++) begin : g_slot
    prod_e cls_i;
    isb_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (advance),
      .load     (writes && (in_dst == RW'(i))),
      .load_cls (prod),
      .load_val (arm_val),
      .cnt      (cnt_vec[i]),
      .cls      (cls_i)
    );
    assign cls_vec[i] = cls_i;
  end

  isb_src_gate #(.RW(RW)) u_gate0 (
    .en(src0_en), .idx(src0_reg), .use_code(src0_use),
    .cnt_vec(cnt_vec), .cls_vec(cls_vec), .blocked(blk0)
  );

  isb_src_gate #(.RW(RW)) u_gate1 (
    .en(src1_en), .idx(src1_reg), .use_code(src1_use),
    .cnt_vec(cnt_vec), .cls_vec(cls_vec), .blocked(blk1)
  );

endmodule

// File: rtl/isb_check.sv
module isb_check #(
  parameter int RW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          advance,
  input logic          in_valid,
  input logic          in_ready,
  input logic [1:0]    in_prod,
  input logic [RW-1:0] in_dst,
  input logic          src0_en,
  input logic [RW-1:0] src0_reg,
  input logic [1:0]    src0_use,
  input logic          src1_en,
  input logic [RW-1:0] src1_reg,
  input logic [1:0]    src1_use,
  input logic          issue_stall
);

  AST_STALL_MEANS_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    issue_stall |-> (in_valid && !in_ready)); // R10

  AST_READY_ON_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> !issue_stall); // R10

  AST_CLEAN_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> in_ready); // R1

  AST_FPU_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_valid && in_ready && in_prod == 2'd3) && in_valid && src0_en &&
     src0_reg == $past(in_dst) && src0_use == 2'd1) |-> issue_stall); // R2

  AST_INT_REWRITE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_valid && in_ready && in_prod == 2'd1) && in_valid && src0_en &&
     !src1_en && src0_reg == $past(in_dst)) |-> !issue_stall); // R6

  AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(issue_stall) && !$past(advance) && in_valid &&
     $stable({in_prod, in_dst, src0_en, src0_reg, src0_use,
              src1_en, src1_reg, src1_use})) |-> issue_stall); // R8

endmodule

bind isb_scoreboard isb_check #(.RW(RW)) u_chk (.*);

// File: tb/isb_scoreboard_bench.sv
`timescale 1ns/1ps
module isb_scoreboard_bench;

  localparam int RW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          advance = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [1:0]    in_prod = 2'd0;
  logic [RW-1:0] in_dst = '0;
  logic          src0_en = 1'b0;
  logic [RW-1:0] src0_reg = '0;
  logic [1:0]    src0_use = 2'd0;
  logic          src1_en = 1'b0;
  logic [RW-1:0] src1_reg = '0;
  logic [1:0]    src1_use = 2'd0;
  logic          issue_stall;

  int  n_run = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #2.5 clk = ~clk;

  isb_scoreboard #(.RW(RW)) u_isb_scoreboard (.*);

  function automatic int need_of(int p, int u);
    if (p == 3) return (u == 2) ? 2 : 3;
    if (p == 2) return (u == 2) ? 0 : 1;
    return 0;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_run++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_srcs();
    src0_en = 0; src1_en = 0; in_prod = 2'd0;
  endtask

  task automatic idle(int n);
    in_valid = 0;
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic produce(int p, int dst);
    clear_srcs();
    in_prod = 2'(p); in_dst = RW'(dst); in_valid = 1;
    @(posedge clk); #1;
    in_valid = 0; in_prod = 2'd0;
  endtask

  // Offer a consumer (no destination) and count stalled cycles until issue.
  task automatic consume(bit e0, int r0, int u0, bit e1, int r1, int u1,
                         output int stalls);
    in_prod = 2'd0;
    src0_en = e0; src0_reg = RW'(r0); src0_use = 2'(u0);
    src1_en = e1; src1_reg = RW'(r1); src1_use = 2'(u1);
    in_valid = 1;
    stalls = 0;
    forever begin
      @(negedge clk);
      if (!issue_stall || stalls > 12) break;
      stalls++;
      @(posedge clk); #1;
    end
    @(posedge clk); #1;
    in_valid = 0; clear_srcs();
  endtask

  initial begin
    int s;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1: every register ready after reset, both use patterns
    for (int r = 0; r < 32; r += 4) begin
      src0_en = 1; src0_reg = RW'(r); src0_use = 2'd1;
      src1_en = 1; src1_reg = RW'(r + 1); src1_use = 2'd0;
      in_valid = 1;
      @(negedge clk);
      check(!issue_stall && in_ready, "R1", issue_stall, 0);
      @(posedge clk); #1;
    end
    in_valid = 0; clear_srcs();

    // R2-R7 sweep: producer x use x gap
    for (int p = 1; p <= 3; p++)
      for (int u = 0; u <= 2; u++)
        for (int g = 0; g <= 4; g++) begin
          int ex;
          produce(p, 3);
          idle(g);
          consume(1, 3, u, 0, 0, 0, s);
          ex = need_of(p, u) - g;
          if (ex < 0) ex = 0;
          if (p == 1)                check(s == ex, "R6", s, ex);
          else if (p == 2 && u == 1) check(s == ex, "R4", s, ex);
          else if (p == 2)           check(s == ex, "R5", s, ex);
          else if (u == 1)           check(s == ex, "R2", s, ex);
          else if (u == 2)           check(s == ex, "R3", s, ex);
          else                       check(s == ex, "R7", s, ex);
          idle(4);
        end

    // R8: freeze while advance is low
    produce(3, 4);
    advance = 0;
    src0_en = 1; src0_reg = RW'(4); src0_use = 2'd1; in_valid = 1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(issue_stall == 1, "R8", issue_stall, 1);
      @(posedge clk); #1;
    end
    advance = 1;
    consume(1, 4, 1, 0, 0, 0, s);
    check(s == 3, "R8", s, 3);
    idle(4);

    // R9: integer rewrite of a pending FP register clears the wait
    produce(3, 5);
    produce(1, 5);
    consume(1, 5, 1, 0, 0, 0, s);
    check(s == 0, "R9", s, 0);
    // R9: FP rewrite of a pending load register extends the wait
    produce(2, 6);
    produce(3, 6);
    consume(1, 6, 2, 0, 0, 0, s);
    check(s == 2, "R9", s, 2);
    idle(4);

    // R10: held then withdrawn producer arms nothing
    produce(3, 4);
    in_prod = 2'd3; in_dst = RW'(7);
    src0_en = 1; src0_reg = RW'(4); src0_use = 2'd1; in_valid = 1;
    @(negedge clk);
    check(issue_stall && !in_ready, "R10", in_ready, 0);
    @(posedge clk); #1;
    in_valid = 0; clear_srcs();
    @(negedge clk);
    check(!issue_stall, "R10", issue_stall, 0);
    idle(4);
    consume(1, 7, 1, 0, 0, 0, s);
    check(s == 0, "R10", s, 0);
    idle(4);

    // R11: disabled source, other register, no-destination producer
    produce(3, 4);
    consume(1, 5, 1, 0, 4, 1, s);
    check(s == 0, "R11", s, 0);
    idle(4);
    produce(0, 8);
    consume(1, 8, 1, 0, 0, 0, s);
    check(s == 0, "R11", s, 0);

    // R12: two sources, larger remaining requirement wins
    produce(3, 2);
    produce(2, 1);
    consume(1, 2, 1, 1, 1, 1, s);
    check(s == 2, "R12", s, 2);
    idle(4);
    produce(2, 1);
    produce(3, 2);
    consume(1, 1, 0, 1, 2, 2, s);
    check(s == 2, "R12", s, 2);

    idle(2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

endmodule